// File: doc/BRIEF.md
# Low-Power Mode Entry and Exit Sequencer

This block is the state machine in the system controller that moves the chip between three power states. In run, everything is clocked. In idle, only the CPU core clock is stopped. In stop, every clock, the PLL and optionally the crystal oscillator are shut down. Software requests idle or stop by writing a mode bit. Only a low-to-high change of that bit is acted on, so software clears the bit after wake-up before it asks again.

Stop entry is an ordered chain of request/acknowledge handshakes:

1. The bus controller drains the CPU's traffic, and then the CPU clock is gated.
2. The bus controller drains all traffic.
3. The memory controller puts SDRAM into self-refresh.
4. After that acknowledge, the system clocks are gated and the system clock source moves to the reference clock. The PLL is switched off, and the oscillator is switched off unless a keep-alive option is set.

A deep variant also switches off CPU core power and holds the core in reset.

An external interrupt, an alarm or a periodic tick wakes the block. On a stop wake-up it does the following, in this order:

1. Restores CPU power.
2. Runs the oscillator for a programmed settle time. This wait is skipped when the oscillator was kept running.
3. Runs the PLL for a programmed lock time.
4. Turns the clocks back on.
5. On the next cycle, releases the self-refresh request, the drain requests and the CPU reset.

A status field records which wake input fired.

Top module: `pwr_seq_top`

## Requirements
- R1: A rising edge on `idle_bit` while in run drops `cpu_clk_en` on the next clock edge. In idle, `sys_clk_en`, `pll_en` and `osc_en` stay high.
- R2: A mode bit that stays high does not trigger again. After it is cleared, a new rising edge triggers again.
- R3: In idle, any high bit of `wake_in` returns the block to run on the next edge. `wake_src` then holds the value of `wake_in` from that cycle, where bit 0 is the external interrupt, bit 1 the alarm and bit 2 the tick.
- R4: A rising edge on `stop_bit` raises `cpu_drain_req` on the next edge. `cpu_clk_en` stays high until `cpu_drain_ack` has been seen.
- R5: After `cpu_drain_ack`, the CPU clock is gated and `sys_drain_req` rises. `sref_req` rises only after `sys_drain_ack`.
- R6: After `sref_ack`, `sys_clk_en` and `pll_en` go low and `clk_src_ref` goes high. `osc_en` goes low unless `osc_keep_cfg` was 1 at the stop edge.
- R7: If `deep_stop_cfg` was 1 at the stop edge, `cpu_pwr_gate` and `cpu_rst` are high while stopped. Otherwise both stay low throughout.
- R8: After a wake in stop, `osc_en` is high with the PLL off for `osc_wait_cnt`+1 cycles. The PLL is then on with the system clocks still off for `pll_wait_cnt`+1 cycles. When the oscillator was kept running, the oscillator wait takes zero cycles.
- R9: During the waits, `cpu_pwr_gate` is low. `sys_clk_en` returns one cycle before `sref_req`, the drain requests and `cpu_rst` drop. `cpu_clk_en` returns in that same later cycle, and `wake_src` records the wake input.
- R10: A mode bit edge outside run is ignored. A stop edge wins over a simultaneous idle edge. A wake input before stop is reached has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Active-low reset |
| idle_bit | input | 1 | Software idle request bit |
| stop_bit | input | 1 | Software stop request bit |
| deep_stop_cfg | input | 1 | Gate CPU power in stop |
| osc_keep_cfg | input | 1 | Keep oscillator running in stop |
| osc_wait_cnt | input | CNT_W | Oscillator settle count |
| pll_wait_cnt | input | CNT_W | PLL lock count |
| cpu_drain_ack | input | 1 | CPU bus traffic drained |
| sys_drain_ack | input | 1 | All bus traffic drained |
| sref_ack | input | 1 | SDRAM in self-refresh |
| wake_in | input | NUM_WAKE | Wake sources: interrupt, alarm, tick |
| cpu_clk_en | output | 1 | CPU core clock enable |
| sys_clk_en | output | 1 | System clock enable |
| clk_src_ref | output | 1 | System clock taken from reference |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Crystal oscillator enable |
| cpu_drain_req | output | 1 | Request CPU bus drain |
| sys_drain_req | output | 1 | Request full bus drain |
| sref_req | output | 1 | Request SDRAM self-refresh |
| cpu_pwr_gate | output | 1 | CPU core power off |
| cpu_rst | output | 1 | CPU core reset |
| wake_src | output | NUM_WAKE | Last wake inputs seen |

## Verification
All outputs are decoded from the state register, so a wrong state shows on the control pins one clock edge after the transition that caused it. A skipped handshake shows at once as a request rising before its predecessor's acknowledge. A mis-loaded or stuck wait timer shows as an oscillator or PLL window whose length differs from the programmed count plus one, or as a run that never returns. A wrong deep or keep-alive latch shows in the first stopped cycle on `cpu_pwr_gate`, `cpu_rst` or `osc_en`.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;

   localparam int MODE_IDLE = 0;
   localparam int MODE_STOP = 1;
   localparam int NUM_MODES = 2;

   typedef enum logic [3:0] {
      ST_RUN,
      ST_IDLE,
      ST_CPU_DRAIN,
      ST_SYS_DRAIN,
      ST_SREF,
      ST_STOP,
      ST_OSC_WAIT,
      ST_PLL_WAIT,
      ST_RESUME
   } pwr_state_e;

   typedef struct packed {
      logic cpu_clk_en;
      logic sys_clk_en;
      logic clk_src_ref;
      logic pll_en;
      logic osc_en;
      logic cpu_drain_req;
      logic sys_drain_req;
      logic sref_req;
      logic cpu_pwr_gate;
      logic cpu_rst;
   } pwr_ctl_t;

endpackage

// File: rtl/pwr_rise_det.sv
`timescale 1ns/1ps
module pwr_rise_det (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic rise
);
   logic level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level;
   end

   assign rise = level & ~level_q;
endmodule

// File: rtl/pwr_wait_timer.sv
`timescale 1ns/1ps
module pwr_wait_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= load_val;
      else if (cnt != '0)   cnt <= cnt - ONE;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/pwr_ctl_decode.sv
`timescale 1ns/1ps
module pwr_ctl_decode
   import pwr_seq_pkg::*;
(
   input  pwr_state_e state,
   input  logic       deep_q,
   input  logic       keep_q,
   output pwr_ctl_t   ctl
);
   always_comb begin
      ctl = '{cpu_clk_en: 1'b1, sys_clk_en: 1'b1, clk_src_ref: 1'b0,
              pll_en: 1'b1, osc_en: 1'b1, cpu_drain_req: 1'b0,
              sys_drain_req: 1'b0, sref_req: 1'b0, cpu_pwr_gate: 1'b0,
              cpu_rst: 1'b0};
      case (state)
         ST_IDLE: ctl.cpu_clk_en = 1'b0;
         ST_CPU_DRAIN: ctl.cpu_drain_req = 1'b1;
         ST_SYS_DRAIN, ST_SREF: begin
            ctl.cpu_drain_req = 1'b1;
            ctl.sys_drain_req = 1'b1;
            ctl.cpu_clk_en    = 1'b0;
            ctl.sref_req      = (state == ST_SREF);
         end
         ST_STOP, ST_OSC_WAIT, ST_PLL_WAIT, ST_RESUME: begin
            ctl.cpu_drain_req = 1'b1;
            ctl.sys_drain_req = 1'b1;
            ctl.sref_req      = 1'b1;
            ctl.cpu_clk_en    = 1'b0;
            ctl.cpu_rst       = deep_q;
            ctl.sys_clk_en    = (state == ST_RESUME);
            ctl.clk_src_ref   = (state != ST_RESUME);
            ctl.pll_en        = (state == ST_PLL_WAIT) || (state == ST_RESUME);
            ctl.osc_en        = (state != ST_STOP) || keep_q;
            ctl.cpu_pwr_gate  = (state == ST_STOP) && deep_q;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/pwr_seq_top.sv
`timescale 1ns/1ps
module pwr_seq_top
   import pwr_seq_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int NUM_WAKE = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                idle_bit,
   input  logic                stop_bit,
   input  logic                deep_stop_cfg,
   input  logic                osc_keep_cfg,
   input  logic [CNT_W-1:0]    osc_wait_cnt,
   input  logic [CNT_W-1:0]    pll_wait_cnt,
   input  logic                cpu_drain_ack,
   input  logic                sys_drain_ack,
   input  logic                sref_ack,
   input  logic [NUM_WAKE-1:0] wake_in,
   output logic                cpu_clk_en,
   output logic                sys_clk_en,
   output logic                clk_src_ref,
   output logic                pll_en,
   output logic                osc_en,
   output logic                cpu_drain_req,
   output logic                sys_drain_req,
   output logic                sref_req,
   output logic                cpu_pwr_gate,
   output logic                cpu_rst,
   output logic [NUM_WAKE-1:0] wake_src
);
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
      $error("pwr_seq_top: CNT_W must lie in 1..32");
   end
   if (NUM_WAKE < 1) begin : g_bad_num_wake
      $error("pwr_seq_top: NUM_WAKE must be at least 1");
   end

   logic [NUM_MODES-1:0] mode_lvl, mode_rise;
   assign mode_lvl[MODE_IDLE] = idle_bit;
   assign mode_lvl[MODE_STOP] = stop_bit;

   for (genvar m = 0; m < NUM_MODES; m++) begin : g_edge
      pwr_rise_det i_rise (
         .clk   (clk),
         .rst_n (rst_n),
         .level (mode_lvl[m]),
         .rise  (mode_rise[m])
      );
   end

   pwr_state_e          state, state_nx;
   logic                deep_q, keep_q;
   logic [NUM_WAKE-1:0] wake_src_q;
   logic                tmr_load, tmr_zero;
   logic [CNT_W-1:0]    tmr_val;
   logic                wake_any;

   assign wake_any = |wake_in;

   always_comb begin
      state_nx = state;
      tmr_load = 1'b0;
      tmr_val  = osc_wait_cnt;
      case (state)
         ST_RUN: begin
            if (mode_rise[MODE_STOP])      state_nx = ST_CPU_DRAIN;
            else if (mode_rise[MODE_IDLE]) state_nx = ST_IDLE;
         end
         ST_IDLE:      if (wake_any)      state_nx = ST_RUN;
         ST_CPU_DRAIN: if (cpu_drain_ack) state_nx = ST_SYS_DRAIN;
         ST_SYS_DRAIN: if (sys_drain_ack) state_nx = ST_SREF;
         ST_SREF:      if (sref_ack)      state_nx = ST_STOP;
         ST_STOP: begin
            if (wake_any) begin
               tmr_load = 1'b1;
               if (keep_q) begin
                  state_nx = ST_PLL_WAIT;
                  tmr_val  = pll_wait_cnt;
               end else begin
                  state_nx = ST_OSC_WAIT;
               end
            end
         end
         ST_OSC_WAIT: begin
            if (tmr_zero) begin
               state_nx = ST_PLL_WAIT;
               tmr_load = 1'b1;
               tmr_val  = pll_wait_cnt;
            end
         end
         ST_PLL_WAIT: if (tmr_zero) state_nx = ST_RESUME;
         ST_RESUME:   state_nx = ST_RUN;
         default:     state_nx = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_RUN;
         deep_q     <= 1'b0;
         keep_q     <= 1'b0;
         wake_src_q <= '0;
      end else begin
         state <= state_nx;
         if (state == ST_RUN && mode_rise[MODE_STOP]) begin
            deep_q <= deep_stop_cfg;
            keep_q <= osc_keep_cfg;
         end
         if ((state == ST_IDLE || state == ST_STOP) && wake_any)
            wake_src_q <= wake_in;
      end
   end

   pwr_wait_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   pwr_ctl_t ctl;

   pwr_ctl_decode i_decode (
      .state  (state),
      .deep_q (deep_q),
      .keep_q (keep_q),
      .ctl    (ctl)
   );

   assign cpu_clk_en    = ctl.cpu_clk_en;
   assign sys_clk_en    = ctl.sys_clk_en;
   assign clk_src_ref   = ctl.clk_src_ref;
   assign pll_en        = ctl.pll_en;
   assign osc_en        = ctl.osc_en;
   assign cpu_drain_req = ctl.cpu_drain_req;
   assign sys_drain_req = ctl.sys_drain_req;
   assign sref_req      = ctl.sref_req;
   assign cpu_pwr_gate  = ctl.cpu_pwr_gate;
   assign cpu_rst       = ctl.cpu_rst;
   assign wake_src      = wake_src_q;
endmodule

// File: rtl/pwr_seq_chk.sv
`timescale 1ns/1ps
module pwr_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic idle_bit,
   input logic cpu_drain_ack,
   input logic sys_drain_ack,
   input logic sref_ack,
   input logic cpu_clk_en,
   input logic sys_clk_en,
   input logic clk_src_ref,
   input logic pll_en,
   input logic osc_en,
   input logic cpu_drain_req,
   input logic sref_req,
   input logic cpu_pwr_gate,
   input logic cpu_rst
);
   // R1: idle entry follows a high idle bit
   a_r1_idle_from_bit: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cpu_clk_en) && !cpu_drain_req) |-> $past(idle_bit));

   // R4: CPU clock only gated after the drain acknowledge
   a_r4_cpu_clk_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cpu_clk_en) && cpu_drain_req) |-> $past(cpu_drain_ack));

   // R5: self-refresh requested only after the full drain
   a_r5_sref_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sref_req) |-> $past(sys_drain_ack));

   // R6: system clocks gated only after self-refresh ack
   a_r6_sys_off_after_sref: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_clk_en) |-> ($past(sref_ack) && clk_src_ref && !pll_en));

   // R7: power gate only with clocks off and core in reset
   a_r7_gate_safe: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_pwr_gate |-> (!cpu_clk_en && !sys_clk_en && cpu_rst));

   // R8: PLL starts only with the oscillator running
   a_r8_pll_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_en) |-> osc_en);

   // R9: clocks back before self-refresh release
   a_r9_clk_before_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sref_req) |-> $past(sys_clk_en));
endmodule

bind pwr_seq_top pwr_seq_chk i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .idle_bit      (idle_bit),
   .cpu_drain_ack (cpu_drain_ack),
   .sys_drain_ack (sys_drain_ack),
   .sref_ack      (sref_ack),
   .cpu_clk_en    (cpu_clk_en),
   .sys_clk_en    (sys_clk_en),
   .clk_src_ref   (clk_src_ref),
   .pll_en        (pll_en),
   .osc_en        (osc_en),
   .cpu_drain_req (cpu_drain_req),
   .sref_req      (sref_req),
   .cpu_pwr_gate  (cpu_pwr_gate),
   .cpu_rst       (cpu_rst)
);

// File: tb/test_pwr_seq_top.sv
`timescale 1ns/1ps
module test_pwr_seq_top;
   localparam int CNT_W    = 8;
   localparam int NUM_WAKE = 3;
   localparam int NVEC     = 4;
   // fields: deep[15] keep[14] wake index[13:12] osc count[11:6] pll count[5:0]
   localparam logic [15:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 2'd0, 6'd3, 6'd2},
      {1'b1, 1'b0, 2'd1, 6'd0, 6'd5},
      {1'b0, 1'b1, 2'd2, 6'd7, 6'd0},
      {1'b1, 1'b1, 2'd0, 6'd4, 6'd1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic idle_bit = 1'b0, stop_bit = 1'b0;
   logic deep_stop_cfg = 1'b0, osc_keep_cfg = 1'b0;
   logic [CNT_W-1:0] osc_wait_cnt = '0, pll_wait_cnt = '0;
   logic cpu_drain_ack = 1'b0, sys_drain_ack = 1'b0, sref_ack = 1'b0;
   logic [NUM_WAKE-1:0] wake_in = '0;
   logic cpu_clk_en, sys_clk_en, clk_src_ref, pll_en, osc_en;
   logic cpu_drain_req, sys_drain_req, sref_req, cpu_pwr_gate, cpu_rst;
   logic [NUM_WAKE-1:0] wake_src;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pwr_seq_top #(.CNT_W(CNT_W), .NUM_WAKE(NUM_WAKE)) i_pwr_seq_top (
      .clk(clk), .rst_n(rst_n), .idle_bit(idle_bit), .stop_bit(stop_bit),
      .deep_stop_cfg(deep_stop_cfg), .osc_keep_cfg(osc_keep_cfg),
      .osc_wait_cnt(osc_wait_cnt), .pll_wait_cnt(pll_wait_cnt),
      .cpu_drain_ack(cpu_drain_ack), .sys_drain_ack(sys_drain_ack),
      .sref_ack(sref_ack), .wake_in(wake_in), .cpu_clk_en(cpu_clk_en),
      .sys_clk_en(sys_clk_en), .clk_src_ref(clk_src_ref), .pll_en(pll_en),
      .osc_en(osc_en), .cpu_drain_req(cpu_drain_req),
      .sys_drain_req(sys_drain_req), .sref_req(sref_req),
      .cpu_pwr_gate(cpu_pwr_gate), .cpu_rst(cpu_rst), .wake_src(wake_src)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic run_stop(bit deep, bit keep, int on, int pn, int widx);
      int n;
      deep_stop_cfg = deep; osc_keep_cfg = keep;
      osc_wait_cnt = CNT_W'(on); pll_wait_cnt = CNT_W'(pn);
      stop_bit = 1'b1;
      step();
      chk("R4 drain req raised", cpu_drain_req, 1);
      step();
      chk("R4 cpu clock held without ack", cpu_clk_en, 1);
      cpu_drain_ack = 1'b1;
      step();
      chk("R5 cpu clock gated", cpu_clk_en, 0);
      chk("R5 sys drain req", sys_drain_req, 1);
      step();
      chk("R5 no sref before sys ack", sref_req, 0);
      sys_drain_ack = 1'b1;
      step();
      chk("R5 sref req", sref_req, 1);
      chk("R5 sys clock still on", sys_clk_en, 1);
      sref_ack = 1'b1;
      step();
      chk("R6 sys clock off", sys_clk_en, 0);
      chk("R6 source ref", clk_src_ref, 1);
      chk("R6 pll off", pll_en, 0);
      chk("R6 osc keep", osc_en, keep);
      chk("R7 power gate", cpu_pwr_gate, deep);
      chk("R7 cpu reset", cpu_rst, deep);
      wake_in = NUM_WAKE'(1 << widx);
      step();
      wake_in = '0;
      chk("R9 power restored", cpu_pwr_gate, 0);
      n = 0;
      while (osc_en && !pll_en && !sys_clk_en && n < 1000) begin n++; step(); end
      chk("R8 osc wait cycles", n, keep ? 0 : on + 1);
      n = 0;
      while (pll_en && !sys_clk_en && n < 1000) begin n++; step(); end
      chk("R8 pll wait cycles", n, pn + 1);
      chk("R9 clocks back first", sys_clk_en, 1);
      chk("R9 sref still held", sref_req, 1);
      chk("R9 cpu reset still held", cpu_rst, deep);
      chk("R9 source back to pll", clk_src_ref, 0);
      step();
      chk("R9 sref released", sref_req, 0);
      chk("R9 drain released", sys_drain_req | cpu_drain_req, 0);
      chk("R9 cpu reset released", cpu_rst, 0);
      chk("R9 cpu clock on", cpu_clk_en, 1);
      chk("R9 wake source", wake_src, 1 << widx);
      stop_bit = 1'b0; cpu_drain_ack = 1'b0; sys_drain_ack = 1'b0; sref_ack = 1'b0;
      step();
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      chk("R1 reset cpu clock", cpu_clk_en, 1);
      chk("R6 reset sys clock", sys_clk_en, 1);
      chk("R6 reset pll/osc", pll_en & osc_en, 1);
      chk("R4 reset requests", cpu_drain_req | sys_drain_req | sref_req, 0);
      chk("R3 reset wake source", wake_src, 0);

      for (int v = 0; v < NVEC; v++)
         run_stop(VEC[v][15], VEC[v][14], int'(VEC[v][11:6]), int'(VEC[v][5:0]),
                  int'(VEC[v][13:12]));

      // idle entry, exit and no retrigger
      idle_bit = 1'b1;
      step();
      chk("R1 idle cpu clock off", cpu_clk_en, 0);
      chk("R1 idle others on", sys_clk_en & pll_en & osc_en, 1);
      step();
      chk("R1 idle holds", cpu_clk_en, 0);
      wake_in = 3'b100;
      step();
      wake_in = '0;
      chk("R3 idle exit", cpu_clk_en, 1);
      chk("R3 tick recorded", wake_src, 4);
      step(); step();
      chk("R2 held bit no retrigger", cpu_clk_en, 1);
      idle_bit = 1'b0; step();
      idle_bit = 1'b1; step();
      chk("R2 rearmed edge triggers", cpu_clk_en, 0);

      // stop edge ignored in idle
      stop_bit = 1'b1; step();
      chk("R10 stop ignored in idle", cpu_drain_req, 0);
      chk("R10 still idle", cpu_clk_en, 0);
      wake_in = 3'b001; step(); wake_in = '0;
      chk("R3 ext exit", cpu_clk_en, 1);
      step();
      chk("R10 stale stop edge not kept", cpu_drain_req, 0);
      idle_bit = 1'b0; stop_bit = 1'b0; step();

      // simultaneous edges and early wake
      deep_stop_cfg = 1'b0; osc_keep_cfg = 1'b0;
      osc_wait_cnt = 8'd2; pll_wait_cnt = 8'd2;
      idle_bit = 1'b1; stop_bit = 1'b1; step();
      chk("R10 stop wins", cpu_drain_req, 1);
      chk("R10 cpu clock on in drain", cpu_clk_en, 1);
      wake_in = 3'b010; step(); wake_in = '0;
      chk("R10 early wake ignored", cpu_drain_req & ~sys_drain_req, 1);
      cpu_drain_ack = 1'b1; sys_drain_ack = 1'b1; sref_ack = 1'b1;
      step(); step(); step();
      chk("R6 stopped", sys_clk_en, 0);
      wake_in = 3'b010; step(); wake_in = '0;
      for (int g = 0; g < 100 && !cpu_clk_en; g++) step();
      chk("R9 back in run", cpu_clk_en, 1);
      chk("R3 alarm recorded", wake_src, 2);
      idle_bit = 1'b0; stop_bit = 1'b0;
      cpu_drain_ack = 1'b0; sys_drain_ack = 1'b0; sref_ack = 1'b0;
      step();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule